// File: doc/BRIEF.md
# Reservation Station Pool

This block is a small pool of waiting slots in front of one functional unit of an out-of-order core. The issue side hands it an operation and two source operands; each operand comes either as a value or as the tag of the station that will produce it. Tag 0 means the value is present. Giving a tag instead of a value renames the source register. The block stores the operation in its lowest free slot and returns that slot's tag, numbered from 1, so the issue side can rename the destination.

Every slot watches one shared result bus. The bus carries a 64-bit value and a 4-bit tag naming the producer. A pending operand takes the bus value when the bus tag equals the tag it is waiting for. Any number of slots, and both operands of one slot, can take the same broadcast in the same cycle. A slot whose two operands both hold values is offered to the execution unit through a valid/ready handshake. When several slots are ready, the lowest index is offered first, and at most one slot is handed over per clock. A handed-over slot stays occupied until the bus carries its own tag, and it becomes free in the next cycle. A synchronous flush empties the pool.

Top module: `rsp_pool`

## Requirements
- R1: After reset, and in the cycle after a flush, `iss_stall` is 0, `ex_valid` is 0 and `iss_tag` is 1.
- R2: `iss_stall` is 1 exactly when every slot is occupied. An issue presented while `iss_stall` is 1 is ignored and never reaches `ex_valid`.
- R3: `iss_tag` is the index plus 1 of the lowest free slot, or 0 while stalled. An accepted issue takes that tag. An operand tag of 0 means its value field is already valid.
- R4: A slot operand that waits on tag T takes `bus_val` and becomes ready when `bus_valid` is 1 and `bus_tag` equals T. Every operand waiting on T captures in that same cycle.
- R5: A broadcast whose tag differs from the awaited tag leaves the operand waiting.
- R6: A slot is offered on `ex_valid` only when both of its operands hold values. `ex_op`, `ex_a`, `ex_b` and `ex_tag` then carry that slot's operation, operand values and tag.
- R7: Among ready slots the lowest index is offered. At most one slot is handed over per cycle, and only when `ex_valid` and `ex_ready` are both 1. An offer not taken stays valid.
- R8: A handed-over slot is never offered again. It stays occupied until a broadcast carries its own tag, and it is free in the next cycle.
- R9: When a broadcast arrives in the same cycle as an issue and matches an issued operand's tag, the new slot stores the bus value for that operand.
- R10: `flush` empties every slot at the next clock edge. A later broadcast of a flushed slot's awaited tag produces no offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties all slots at the next edge |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 6 | Operation code to store |
| iss_a_tag | input | 4 | Producer tag of operand A, 0 if value given |
| iss_a_val | input | 64 | Value of operand A when its tag is 0 |
| iss_b_tag | input | 4 | Producer tag of operand B, 0 if value given |
| iss_b_val | input | 64 | Value of operand B when its tag is 0 |
| iss_stall | output | 1 | No free slot; issue not accepted |
| iss_tag | output | 4 | Tag the next accepted issue receives |
| bus_valid | input | 1 | Result broadcast valid |
| bus_tag | input | 4 | Tag of the producer of the broadcast |
| bus_val | input | 64 | Broadcast result value |
| ex_valid | output | 1 | A ready slot is offered to execution |
| ex_ready | input | 1 | Execution unit takes the offer |
| ex_op | output | 6 | Operation of the offered slot |
| ex_a | output | 64 | Operand A of the offered slot |
| ex_b | output | 64 | Operand B of the offered slot |
| ex_tag | output | 4 | Tag of the offered slot |

## Verification
Three situations are hard to reach from the ports. The first is a broadcast that lands in the same cycle as the issue waiting on it. The bench drives both in one clock, for operand A of one slot and operand B of another. The second is one broadcast waking several slots at once. The bench fills the whole pool with slots waiting on a single tag, tries one more issue while stalled, then broadcasts the tag. It expects exactly four offers in index order and no fifth one. The third is freeing a slot, which needs a dispatch followed by its own tag on the bus. The bench checks that the freed slot, and no lower one, comes back in `iss_tag`.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
   typedef enum logic [1:0] {
      SLOT_IDLE = 2'd0,
      SLOT_HELD = 2'd1,
      SLOT_SENT = 2'd2
   } slot_state_e;
endpackage

// File: rtl/rsp_pick.sv
module rsp_pick #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !any) begin
            gnt[i] = 1'b1;
            idx    = IW'(i);
            any    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/rsp_operand.sv
module rsp_operand #(
   parameter int DATA_W = 64,
   parameter int TAG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [DATA_W-1:0] in_val,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_val,
   output logic              out_have,
   output logic [DATA_W-1:0] out_val
);
   logic [TAG_W-1:0]  tag_q;
   logic [DATA_W-1:0] val_q;
   logic              hit_in, hit_held;

   assign hit_in   = bus_valid && (in_tag != '0) && (bus_tag == in_tag);
   assign hit_held = bus_valid && (tag_q != '0) && (bus_tag == tag_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q <= '0;
         val_q <= '0;
      end else if (load) begin
         tag_q <= hit_in ? '0 : in_tag;
         val_q <= hit_in ? bus_val : in_val;
      end else if (hit_held) begin
         tag_q <= '0;
         val_q <= bus_val;
      end
   end

   assign out_have = (tag_q == '0);
   assign out_val  = val_q;

   // R4: a matching broadcast is captured into a waiting operand
   a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
      hit_held && !load |=> out_have && (out_val == $past(bus_val)));

   // R9: a broadcast in the issue cycle is forwarded into the new operand
   a_r9_forward: assert property (@(posedge clk) disable iff (!rst_n)
      load && hit_in |=> out_have && (out_val == $past(bus_val)));
endmodule

// File: rtl/rsp_slot.sv
module rsp_slot
   import rsp_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int TAG_W  = 4,
   parameter int OP_W   = 6,
   parameter int MY_TAG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              alloc,
   input  logic [OP_W-1:0]   in_op,
   input  logic [TAG_W-1:0]  in_a_tag,
   input  logic [DATA_W-1:0] in_a_val,
   input  logic [TAG_W-1:0]  in_b_tag,
   input  logic [DATA_W-1:0] in_b_val,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_val,
   input  logic              grant,
   output logic              out_busy,
   output logic              out_ready,
   output logic [OP_W-1:0]   out_op,
   output logic [DATA_W-1:0] out_a,
   output logic [DATA_W-1:0] out_b
);
   slot_state_e st_q;
   logic [OP_W-1:0] op_q;
   logic a_have, b_have, own_hit;

   assign own_hit = bus_valid && (bus_tag == TAG_W'(MY_TAG));

   rsp_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opa (
      .clk(clk), .rst_n(rst_n), .load(alloc),
      .in_tag(in_a_tag), .in_val(in_a_val),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
      .out_have(a_have), .out_val(out_a));

   rsp_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opb (
      .clk(clk), .rst_n(rst_n), .load(alloc),
      .in_tag(in_b_tag), .in_val(in_b_val),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
      .out_have(b_have), .out_val(out_b));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= SLOT_IDLE;
         op_q <= '0;
      end else if (flush) begin
         st_q <= SLOT_IDLE;
      end else begin
         case (st_q)
            SLOT_IDLE: if (alloc) begin
               st_q <= SLOT_HELD;
               op_q <= in_op;
            end
            SLOT_HELD: if (grant)   st_q <= SLOT_SENT;
            SLOT_SENT: if (own_hit) st_q <= SLOT_IDLE;
            default:                st_q <= SLOT_IDLE;
         endcase
      end
   end

   assign out_busy  = (st_q != SLOT_IDLE);
   assign out_ready = (st_q == SLOT_HELD) && a_have && b_havee_guard;
   logic b_havee_guard;
   assign b_havee_guard = b_have;
   assign out_op    = op_q;

   // R8: a dispatched slot is not offered again
   a_r8_once: assert property (@(posedge clk) disable iff (!rst_n)
      grant && !flush |=> !out_ready);

   // R8: its own broadcast frees a dispatched slot
   a_r8_free: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SLOT_SENT) && own_hit && !flush |=> !out_busy);
endmodule

// File: rtl/rsp_pool.sv
module rsp_pool #(
   parameter int N_ST   = 4,
   parameter int DATA_W = 64,
   parameter int TAG_W  = 4,
   parameter int OP_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              iss_valid,
   input  logic [OP_W-1:0]   iss_op,
   input  logic [TAG_W-1:0]  iss_a_tag,
   input  logic [DATA_W-1:0] iss_a_val,
   input  logic [TAG_W-1:0]  iss_b_tag,
   input  logic [DATA_W-1:0] iss_b_val,
   output logic              iss_stall,
   output logic [TAG_W-1:0]  iss_tag,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_val,
   output logic              ex_valid,
   input  logic              ex_ready,
   output logic [OP_W-1:0]   ex_op,
   output logic [DATA_W-1:0] ex_a,
   output logic [DATA_W-1:0] ex_b,
   output logic [TAG_W-1:0]  ex_tag
);
   localparam int IW      = (N_ST > 1) ? $clog2(N_ST) : 1;
   localparam int MAX_TAG = (1 << TAG_W) - 1;

   if (N_ST < 1 || N_ST > MAX_TAG) begin : g_bad_depth
      $error("rsp_pool: N_ST must lie in 1..2**TAG_W-1");
   end
   if (DATA_W < 1 || OP_W < 1) begin : g_bad_width
      $error("rsp_pool: DATA_W and OP_W must be positive");
   end

   logic [N_ST-1:0]   busy, ready, alloc, grant, free_gnt, disp_gnt;
   logic [IW-1:0]     free_idx, disp_idx;
   logic              free_any;
   logic [OP_W-1:0]   op_arr [N_ST];
   logic [DATA_W-1:0] a_arr  [N_ST];
   logic [DATA_W-1:0] b_arr  [N_ST];

   rsp_pick #(.N(N_ST)) u_free (
      .req(~busy), .gnt(free_gnt), .idx(free_idx), .any(free_any));

   rsp_pick #(.N(N_ST)) u_disp (
      .req(ready), .gnt(disp_gnt), .idx(disp_idx), .any(ex_valid));

   assign iss_stall = !free_any;
   assign iss_tag   = free_any ? TAG_W'(free_idx) + TAG_W'(1) : '0;
   assign alloc     = (iss_valid && free_any) ? free_gnt : '0;
   assign grant     = (ex_valid && ex_ready) ? disp_gnt : '0;

   for (genvar g = 0; g < N_ST; g++) begin : g_slot
      rsp_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .MY_TAG(g + 1)) u_slot (
         .clk(clk), .rst_n(rst_n), .flush(flush), .alloc(alloc[g]),
         .in_op(iss_op), .in_a_tag(iss_a_tag), .in_a_val(iss_a_val),
         .in_b_tag(iss_b_tag), .in_b_val(iss_b_val),
         .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
         .grant(grant[g]), .out_busy(busy[g]), .out_ready(ready[g]),
         .out_op(op_arr[g]), .out_a(a_arr[g]), .out_b(b_arr[g]));
   end

   assign ex_op  = op_arr[disp_idx];
   assign ex_a   = a_arr[disp_idx];
   assign ex_b   = b_arr[disp_idx];
   assign ex_tag = ex_valid ? TAG_W'(disp_idx) + TAG_W'(1) : '0;

   // R7: at most one slot handed over per cycle
   a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R7: an offer not taken remains valid
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ex_valid && !ex_ready && !flush |=> ex_valid);

   // R1 / R10: flush leaves an empty pool
   a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !iss_stall && !ex_valid);

   // R2: a stalled issue does not change occupancy
   a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      iss_stall && !flush && !bus_valid |=> iss_stall);
endmodule

// File: tb/rsp_pool_tb.sv
module rsp_pool_tb;
   logic        clk = 1'b0;
   logic        rst_n, flush, iss_valid, bus_valid, ex_ready;
   logic [5:0]  iss_op;
   logic [3:0]  iss_a_tag, iss_b_tag, bus_tag;
   logic [63:0] iss_a_val, iss_b_val, bus_val;
   logic        iss_stall, ex_valid;
   logic [3:0]  iss_tag, ex_tag;
   logic [5:0]  ex_op;
   logic [63:0] ex_a, ex_b;
   int          n_tests = 0;
   int          n_fail  = 0;
   logic [3:0]  t;

   always #2 clk = ~clk;

   rsp_pool u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .iss_valid(iss_valid), .iss_op(iss_op),
      .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
      .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
      .iss_stall(iss_stall), .iss_tag(iss_tag),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
      .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_op(ex_op),
      .ex_a(ex_a), .ex_b(ex_b), .ex_tag(ex_tag));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic set_issue(input logic [5:0] op, input logic [3:0] at, input logic [63:0] av,
                            input logic [3:0] bt, input logic [63:0] bv);
      iss_valid = 1'b1; iss_op = op;
      iss_a_tag = at; iss_a_val = av; iss_b_tag = bt; iss_b_val = bv;
   endtask

   task automatic do_issue(input logic [5:0] op, input logic [3:0] at, input logic [63:0] av,
                           input logic [3:0] bt, input logic [63:0] bv, output logic [3:0] tg);
      set_issue(op, at, av, bt, bv);
      settle();
      tg = iss_tag;
      cyc();
      iss_valid = 1'b0;
   endtask

   task automatic do_bcast(input logic [3:0] tg, input logic [63:0] v);
      bus_valid = 1'b1; bus_tag = tg; bus_val = v;
      cyc();
      bus_valid = 1'b0;
   endtask

   task automatic do_flush();
      flush = 1'b1;
      cyc();
      flush = 1'b0;
   endtask

   task automatic t_reset();
      settle();
      chk("R1 stall after reset", iss_stall, 0);
      chk("R1 ex_valid after reset", ex_valid, 0);
      chk("R1 iss_tag after reset", iss_tag, 1);
   endtask

   task automatic t_ready_issue();
      logic [3:0] tg;
      do_flush();
      do_issue(6'd3, 4'd0, 64'h11, 4'd0, 64'h22, tg);
      chk("R3 first tag", tg, 1);
      settle();
      chk("R6 ex_valid", ex_valid, 1);
      chk("R6 ex_tag", ex_tag, 1);
      chk("R6 ex_op", ex_op, 3);
      chk("R6 ex_a", ex_a, 64'h11);
      chk("R6 ex_b", ex_b, 64'h22);
      cyc(); settle();
      chk("R7 offer held", ex_valid, 1);
      ex_ready = 1'b1; cyc(); ex_ready = 1'b0; settle();
      chk("R8 not re-offered", ex_valid, 0);
      chk("R8 still occupied", iss_tag, 2);
      do_bcast(4'd1, 64'h0); settle();
      chk("R8 freed by own tag", iss_tag, 1);
   endtask

   task automatic t_capture();
      logic [3:0] tg;
      do_flush();
      do_issue(6'd1, 4'd5, 64'h0, 4'd0, 64'hB0, tg);
      do_issue(6'd2, 4'd0, 64'hA0, 4'd5, 64'h0, tg);
      do_issue(6'd3, 4'd6, 64'h0, 4'd0, 64'hC0, tg);
      settle();
      chk("R6 nothing ready", ex_valid, 0);
      do_bcast(4'd7, 64'h77); settle();
      chk("R5 mismatched tag", ex_valid, 0);
      do_bcast(4'd5, 64'h5555); settle();
      chk("R4 capture valid", ex_valid, 1);
      chk("R7 lowest first", ex_tag, 1);
      chk("R4 slot1 a", ex_a, 64'h5555);
      chk("R4 slot1 b", ex_b, 64'hB0);
      ex_ready = 1'b1; cyc(); settle();
      chk("R4 second slot same cycle", ex_tag, 2);
      chk("R4 slot2 a", ex_a, 64'hA0);
      chk("R4 slot2 b", ex_b, 64'h5555);
      cyc(); ex_ready = 1'b0; settle();
      chk("R5 slot3 still waits", ex_valid, 0);
      do_bcast(4'd6, 64'h66); settle();
      chk("R4 slot3 wakes", ex_tag, 3);
      chk("R4 slot3 a", ex_a, 64'h66);
   endtask

   task automatic t_full();
      logic [3:0] tg;
      do_flush();
      for (int k = 1; k <= 4; k++) begin
         do_issue(6'(k), 4'd9, 64'h0, 4'd0, 64'(k * 16), tg);
         chk("R3 ascending tag", tg, 64'(k));
      end
      settle();
      chk("R2 stall when full", iss_stall, 1);
      chk("R3 tag 0 when full", iss_tag, 0);
      do_issue(6'd7, 4'd0, 64'hEE, 4'd0, 64'hFF, tg);
      do_bcast(4'd9, 64'h99);
      ex_ready = 1'b1;
      for (int k = 1; k <= 4; k++) begin
         settle();
         chk("R7 offer order", ex_tag, 64'(k));
         chk("R4 broadcast to all", ex_a, 64'h99);
         chk("R6 op of offer", ex_op, 64'(k));
         cyc();
      end
      ex_ready = 1'b0; settle();
      chk("R2 stalled issue ignored", ex_valid, 0);
      do_bcast(4'd2, 64'h0); settle();
      chk("R8 freed slot unstalls", iss_stall, 0);
      chk("R3 lowest free tag", iss_tag, 2);
   endtask

   task automatic t_forward();
      logic [3:0] tg;
      do_flush();
      do_issue(6'd4, 4'd10, 64'h0, 4'd0, 64'h1, tg);
      set_issue(6'd5, 4'd0, 64'h2, 4'd10, 64'h0);
      bus_valid = 1'b1; bus_tag = 4'd10; bus_val = 64'hABC;
      cyc();
      iss_valid = 1'b0; bus_valid = 1'b0; settle();
      chk("R9 first slot offered", ex_tag, 1);
      chk("R9 first slot a", ex_a, 64'hABC);
      ex_ready = 1'b1; cyc(); ex_ready = 1'b0; settle();
      chk("R9 forwarded slot offered", ex_tag, 2);
      chk("R9 forwarded b", ex_b, 64'hABC);
      chk("R9 forwarded a", ex_a, 64'h2);
   endtask

   task automatic t_flush();
      logic [3:0] tg;
      do_flush();
      do_issue(6'd1, 4'd11, 64'h0, 4'd0, 64'h3, tg);
      do_issue(6'd2, 4'd0, 64'h4, 4'd0, 64'h5, tg);
      settle();
      chk("R10 pre-flush offer", ex_valid, 1);
      do_flush(); settle();
      chk("R10 flush clears offer", ex_valid, 0);
      chk("R1 stall after flush", iss_stall, 0);
      chk("R1 tag after flush", iss_tag, 1);
      do_bcast(4'd11, 64'h12); settle();
      chk("R10 flushed slot stays empty", ex_valid, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; flush = 1'b0; iss_valid = 1'b0; bus_valid = 1'b0; ex_ready = 1'b0;
      iss_op = '0; iss_a_tag = '0; iss_b_tag = '0; iss_a_val = '0; iss_b_val = '0;
      bus_tag = '0; bus_val = '0;
      cyc(); cyc();
      rst_n = 1'b1;
      t_reset();
      t_ready_issue();
      t_capture();
      t_full();
      t_forward();
      t_flush();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule